// File: doc/BRIEF.md
# Brute-Force Hash Search Controller

This block searches one bounded range of candidate values for a preimage of a known digest. A host supplies a salt, a target digest and an inclusive range of candidates, then pulses a start strobe. The block captures these values and walks the candidates in ascending order. For each candidate it sends the salt joined with the candidate to an external hash engine and compares the digest that comes back with the target.

The hash function is outside the block. It sits behind a request and response pair: a one-cycle request carries the hash input, and a response strobe carries the digest. Only one request is ever in flight. When a digest matches, the block stops and raises a found flag. When the last candidate misses, it raises an exhausted flag instead. The matching candidate is never reported. The host learns only that a match exists somewhere in the range, and it must re-scan that range in software if it needs the value. In normal use the range covers 2^22 candidates. Moving on to the next range and loading new values are the host's job.

Top module: `hash_sweep`

## Requirements
- R1: A one-cycle `startPulse` while idle captures salt, target, start and end bounds. From the next cycle the block is busy and the first request carries the start bound.
- R2: Each request asserts `reqValid` for exactly one cycle, with `reqData` = {salt in the upper SALT_W bits, candidate in the lower CAND_W bits}. No new request is issued until `rspValid` returns the digest of the current one.
- R3: After a mismatching digest the candidate increases by exactly one, so requests cover the range in ascending order with no gaps or repeats.
- R4: When a returned digest equals the target, `found` and `done` rise in the cycle after the response, and no further request is issued.
- R5: The end bound is inclusive. The candidate equal to the end bound is hashed, and only if it also mismatches do `exhausted` and `done` rise.
- R6: `found` and `exhausted` are never high together. Whenever either is high, `done` is high. All three hold their values until the next accepted start, which clears them.
- R7: A `startPulse` while busy is ignored. The running search finishes on its original bounds, salt and target.
- R8: `busy` is low when idle or finished and high from the cycle after an accepted start until the cycle `done` rises.
- R9: A synchronous active-high `rst` returns the block to idle, with `busy`, `done`, `found`, `exhausted` and `reqValid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | One-cycle strobe that begins a search |
| saltIn | input | SALT_W | Salt joined to every candidate |
| targetIn | input | DIGEST_W | Digest being searched for |
| startBound | input | CAND_W | First candidate of the range |
| endBound | input | CAND_W | Last candidate of the range (inclusive) |
| reqValid | output | 1 | One-cycle request to the hash engine |
| reqData | output | SALT_W+CAND_W | Hash input: salt then candidate |
| rspValid | input | 1 | Digest from the engine is valid |
| rspDigest | input | DIGEST_W | Digest returned by the engine |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| found | output | 1 | A candidate in the range matched |
| exhausted | output | 1 | The whole range was tried without a match |

## Verification
Some properties are checked by assertions on every cycle. `found` and `exhausted` are never high together, `done` goes with a result and never with `busy`, and results are held while no start arrives. Requests last one cycle and never overlap an outstanding one, and the candidate never steps past the end bound. Other behaviour can only be shown by the bench's scenarios, which track every request the engine model serves. These include that the range is covered in ascending order, that the inclusive end bound and a match on either bound give the right outcome, that a start during a search is ignored, and that a reset in the middle of a search clears the block.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef struct packed {
    logic loadParams;
    logic issueReq;
    logic stepCand;
  } sweepCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sweepState_t;

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startPulse,
  input  logic      rspValid,
  input  logic      digestMatch,
  input  logic      atEnd,
  output sweepCtl_t ctl,
  output logic      busy,
  output logic      done,
  output logic      found,
  output logic      exhausted
);

  sweepState_t state, nextState;
  logic        rspSeen;

  assign rspSeen = (state == ST_WAIT) && rspValid;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          ctl.loadParams = 1'b1;
          nextState      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        ctl.issueReq = 1'b1;
        nextState    = ST_WAIT;
      end
      ST_WAIT: begin
        if (rspValid) begin
          if (digestMatch || atEnd) begin
            nextState = ST_IDLE;
          end else begin
            ctl.stepCand = 1'b1;
            nextState    = ST_ISSUE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.loadParams) begin
      done      <= 1'b0;
      found     <= 1'b0;
      exhausted <= 1'b0;
    end else if (rspSeen && digestMatch) begin
      done  <= 1'b1;
      found <= 1'b1;
    end else if (rspSeen && atEnd) begin
      done      <= 1'b1;
      exhausted <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  // R6: the two outcomes exclude each other
  assert_outcome_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(found && exhausted));

  // R6: a result is always flagged with done
  assert_result_has_done_R6: assert property (@(posedge clk) disable iff (rst)
    (found || exhausted) |-> done);

  // R8: a finished block is not busy
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: results hold until the next start
  assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !startPulse) |=> (done && $stable(found) && $stable(exhausted)));

  // R7: a start pulse while searching does not reload
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctl.loadParams);

endmodule

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int CAND_W   = 32,
  parameter int SALT_W   = 32,
  parameter int DIGEST_W = 32,
  localparam int REQ_W   = SALT_W + CAND_W
) (
  input  logic                clk,
  input  logic                rst,
  input  sweepCtl_t           ctl,
  input  logic [SALT_W-1:0]   saltIn,
  input  logic [DIGEST_W-1:0] targetIn,
  input  logic [CAND_W-1:0]   startBound,
  input  logic [CAND_W-1:0]   endBound,
  input  logic [DIGEST_W-1:0] rspDigest,
  output logic                reqValid,
  output logic [REQ_W-1:0]    reqData,
  output logic                digestMatch,
  output logic                atEnd
);

  logic [SALT_W-1:0]   saltReg;
  logic [DIGEST_W-1:0] targetReg;
  logic [CAND_W-1:0]   endReg;
  logic [CAND_W-1:0]   candReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      saltReg   <= '0;
      targetReg <= '0;
      endReg    <= '0;
    end else if (ctl.loadParams) begin
      saltReg   <= saltIn;
      targetReg <= targetIn;
      endReg    <= endBound;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      candReg <= '0;
    end else if (ctl.loadParams) begin
      candReg <= startBound;
    end else if (ctl.stepCand) begin
      candReg <= candReg + 1'b1;
    end
  end

  assign reqValid    = ctl.issueReq;
  assign reqData     = {saltReg, candReg};
  assign digestMatch = (rspDigest == targetReg);
  assign atEnd       = (candReg == endReg);

  // R5: the counter never steps beyond the inclusive end bound
  assert_no_step_past_end_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.stepCand |-> !atEnd);

  // R2: a request lasts one cycle
  assert_req_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> !reqValid);

  // R2: the hash input is steady between request and result
  assert_req_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> $stable(reqData));

endmodule

// File: rtl/hash_sweep.sv
module hash_sweep
  import sweep_pkg::*;
#(
  parameter int CAND_W   = 32,
  parameter int SALT_W   = 32,
  parameter int DIGEST_W = 32,
  localparam int REQ_W   = SALT_W + CAND_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startPulse,
  input  logic [SALT_W-1:0]   saltIn,
  input  logic [DIGEST_W-1:0] targetIn,
  input  logic [CAND_W-1:0]   startBound,
  input  logic [CAND_W-1:0]   endBound,
  output logic                reqValid,
  output logic [REQ_W-1:0]    reqData,
  input  logic                rspValid,
  input  logic [DIGEST_W-1:0] rspDigest,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic                exhausted
);

  sweepCtl_t ctl;
  logic      digestMatch;
  logic      atEnd;

  sweep_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .startPulse  (startPulse),
    .rspValid    (rspValid),
    .digestMatch (digestMatch),
    .atEnd       (atEnd),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done),
    .found       (found),
    .exhausted   (exhausted)
  );

  sweep_datapath #(
    .CAND_W   (CAND_W),
    .SALT_W   (SALT_W),
    .DIGEST_W (DIGEST_W)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .saltIn      (saltIn),
    .targetIn    (targetIn),
    .startBound  (startBound),
    .endBound    (endBound),
    .rspDigest   (rspDigest),
    .reqValid    (reqValid),
    .reqData     (reqData),
    .digestMatch (digestMatch),
    .atEnd       (atEnd)
  );

  // R2: no new request while one is outstanding
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid || (busy && !reqValid && !rspValid && !$past(rspValid))) |=> !reqValid || $past(rspValid));

  // R9: requests only while a search runs
  assert_req_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> busy);

endmodule

// File: tb/hash_sweep_tb_top.sv
module hash_sweep_tb_top;

  localparam int CW  = 32;
  localparam int SW  = 32;
  localparam int DW  = 32;
  localparam int RW  = SW + CW;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          startPulse;
  logic [SW-1:0] saltIn;
  logic [DW-1:0] targetIn;
  logic [CW-1:0] startBound;
  logic [CW-1:0] endBound;
  logic          reqValid;
  logic [RW-1:0] reqData;
  logic          rspValid;
  logic [DW-1:0] rspDigest;
  logic          busy, done, found, exhausted;

  int total = 0;
  int bad   = 0;

  int            reqCount;
  int            seqErr;
  logic          firstReq;
  logic [RW-1:0] lastReq;

  always #4 clk = ~clk;

  hash_sweep #(.CAND_W(CW), .SALT_W(SW), .DIGEST_W(DW)) dut_i (
    .clk(clk), .rst(rst), .startPulse(startPulse), .saltIn(saltIn),
    .targetIn(targetIn), .startBound(startBound), .endBound(endBound),
    .reqValid(reqValid), .reqData(reqData), .rspValid(rspValid),
    .rspDigest(rspDigest), .busy(busy), .done(done), .found(found),
    .exhausted(exhausted)
  );

  function automatic logic [DW-1:0] hashFn(input logic [RW-1:0] x);
    logic [63:0] m;
    m = x * 64'h9E37_79B9_7F4A_7C15;
    return m[63:32] ^ m[31:0] ^ x[31:0];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stand-in hash engine, drives only at falling edges
  initial begin
    rspValid  = 1'b0;
    rspDigest = '0;
    forever begin
      @(negedge clk);
      while (reqValid) begin
        if (!firstReq && (reqData[CW-1:0] != lastReq[CW-1:0] + 1)) seqErr++;
        firstReq = 1'b0;
        lastReq  = reqData;
        reqCount++;
        repeat (LAT) @(negedge clk);
        rspDigest = hashFn(lastReq);
        rspValid  = 1'b1;
        @(negedge clk);
        rspValid  = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pulseStart(input logic [SW-1:0] s, input logic [DW-1:0] t,
                            input logic [CW-1:0] lo, input logic [CW-1:0] hi);
    @(negedge clk);
    saltIn = s; targetIn = t; startBound = lo; endBound = hi;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done, {tag, " done reached"}, done, 1);
  endtask

  // run a search and compare with a bench-side model of the range
  task automatic runSearch(input string tag, input logic [SW-1:0] s, input logic [DW-1:0] t,
                           input logic [CW-1:0] lo, input logic [CW-1:0] hi);
    int expCount = 0;
    bit expFound = 0;
    logic [CW-1:0] expLast = hi;
    for (longint c = lo; c <= hi; c++) begin
      expCount++;
      if (hashFn({s, c[CW-1:0]}) == t) begin
        expFound = 1;
        expLast  = c[CW-1:0];
        break;
      end
    end
    reqCount = 0; seqErr = 0; firstReq = 1'b1;
    pulseStart(s, t, lo, hi);
    check(busy, {tag, " R8 busy after start"}, busy, 1);
    waitDone(tag);
    check(found == expFound, {tag, " R4 found"}, found, expFound);
    check(exhausted == !expFound, {tag, " R5 exhausted"}, exhausted, !expFound);
    check(!busy, {tag, " R8 idle when done"}, busy, 0);
    check(reqCount == expCount, {tag, " R3 request count"}, reqCount, expCount);
    check(seqErr == 0, {tag, " R3 ascending order"}, seqErr, 0);
    check(lastReq == {s, expLast}, {tag, " R2 last hash input"}, lastReq[CW-1:0], expLast);
    repeat (6) @(negedge clk);
    check(reqCount == expCount, {tag, " R4 no request after finish"}, reqCount, expCount);
  endtask

  task automatic testReset();
    check(!busy && !done && !found && !exhausted && !reqValid, "R9 reset state",
          {busy, done, found, exhausted, reqValid}, 0);
  endtask

  task automatic testFirstRequest();
    reqCount = 0; seqErr = 0; firstReq = 1'b1;
    pulseStart(32'h1111_2222, 32'h0, 32'd500, 32'd520);
    // the request issued after the start cycle carries the start bound
    check(reqValid && reqData == {32'h1111_2222, 32'd500}, "R1 first request",
          reqData[CW-1:0], 500);
    @(negedge clk);
    check(!reqValid, "R2 request one cycle", reqValid, 0);
    waitDone("first");
  endtask

  task automatic testHoldAndClear();
    repeat (5) @(negedge clk);
    check(done && (found || exhausted), "R6 flags held", done, 1);
    pulseStart(32'h5, 32'h0, 32'd0, 32'd3);
    check(!done && !found && !exhausted && busy, "R6 flags cleared by start",
          {done, found, exhausted}, 0);
    waitDone("clear");
  endtask

  task automatic testIgnoreStart();
    logic [SW-1:0] s = 32'hABCD_0001;
    logic [DW-1:0] t = hashFn({s, 32'd130});
    reqCount = 0; seqErr = 0; firstReq = 1'b1;
    pulseStart(s, t, 32'd100, 32'd140);
    repeat (20) @(negedge clk);
    pulseStart(32'h0, 32'h0, 32'd0, 32'd5);
    waitDone("ignore");
    check(found, "R7 original target still found", found, 1);
    check(reqCount == 31, "R7 original range kept", reqCount, 31);
    check(lastReq == {s, 32'd130}, "R7 original salt kept", lastReq[CW-1:0], 130);
  endtask

  task automatic testMidReset();
    pulseStart(32'h77, 32'h0, 32'd0, 32'd200);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(!busy && !done && !found && !exhausted && !reqValid, "R9 reset mid-search",
          {busy, done, found, exhausted}, 0);
  endtask

  initial begin
    rst = 1'b1; startPulse = 1'b0;
    saltIn = '0; targetIn = '0; startBound = '0; endBound = '0;
    reqCount = 0; seqErr = 0; firstReq = 1'b1; lastReq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testFirstRequest();
    runSearch("mid-match", 32'hDEAD_BEEF, hashFn({32'hDEAD_BEEF, 32'd1037}), 32'd1000, 32'd1060);
    runSearch("no-match", 32'h0BAD_F00D, hashFn({32'h0BAD_F00D, 32'd9999}), 32'd40, 32'd80);
    runSearch("match-at-end", 32'h1234_5678, hashFn({32'h1234_5678, 32'd300}), 32'd270, 32'd300);
    runSearch("match-at-start", 32'h0, hashFn({32'h0, 32'd7}), 32'd7, 32'd30);
    runSearch("single-miss", 32'h99, hashFn({32'h99, 32'd1}), 32'd2, 32'd2);
    testHoldAndClear();
    testIgnoreStart();
    testMidReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule